// File: doc/BRIEF.md
# Interval and Frequency Meter

This block counts cycles of its own clock to measure time. In interval mode it counts the cycles from a rising edge on a start input to a later rising edge on a stop input. The result N stands for a time of roughly N reference periods, and the resolution is one reference period. Both inputs may change at any time with respect to the clock. Each input passes through its own two-flop synchroniser, and its rising edge is taken as a 0-to-1 change of the synchronised value. Both paths have the same latency, so that latency cancels out of the count.

In frequency mode a periodic signal drives the start input. The gate opens on one rising edge and closes on the M-th edge after it. The block reports both N and M, and logic downstream forms the frequency as M / (N × Tc). Repeat mode takes K = 2^s interval measurements in a row and adds them into a wide accumulator. The average is the sum shifted right by s, so no divider is needed. The mode, M and s are captured when the block is armed. Each result comes with a one-cycle done pulse, and the block stays busy until the result is acknowledged.

Top module: `interval_freq_meter`

## Requirements
- R1: After reset, busy, done, overflow, result_count, accum_sum and accum_avg are all 0, and result_periods is 1.
- R2: In interval mode (mode code 0), result_count equals the number of clock cycles between the synchronised start rising edge and the synchronised stop rising edge. Stop rising edges that occur one or more cycles after the start edge therefore give a count of 1 or more.
- R3: While the block waits for the start edge, stop rising edges are ignored. While an interval measurement is counting, further start rising edges are ignored.
- R4: In frequency mode (mode code 1), result_count is the number of cycles from the first synchronised start rising edge to the M-th rising edge after it. result_periods reports M. A programmed M of 0 is treated as 1.
- R5: In repeat mode (mode code 2), K = 2^repeat_log2 interval measurements are summed into accum_sum. accum_avg equals accum_sum shifted right by repeat_log2. Only one done pulse is produced, after the K-th measurement.
- R6: The count saturates at 2^CW−1. When it reaches that value, the measurement ends with overflow set and result_count equal to 2^CW−1.
- R7: done is high for exactly one cycle per result. busy rises on an accepted arm and stays high until ack is given while the result is held. It falls one cycle after that ack.
- R8: arm is ignored while busy. mode, periods_m and repeat_log2 are captured on an accepted arm, so later changes to these inputs do not affect the measurement in progress.
- R9: Mode code 3 behaves exactly as interval mode. In interval and repeat modes, result_periods reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (counter) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Starts a new measurement when the block is not busy |
| mode | input | 2 | 0 interval, 1 frequency, 2 repeat, 3 interval |
| periods_m | input | MW | Number of periods M in the frequency gate |
| repeat_log2 | input | KW | log2 of the repeat count K |
| start_in | input | 1 | Asynchronous start edge, or the periodic input in frequency mode |
| stop_in | input | 1 | Asynchronous stop edge |
| ack | input | 1 | Releases a held result |
| busy | output | 1 | Measurement in progress or result held |
| done | output | 1 | One-cycle result strobe |
| overflow | output | 1 | Count saturated before the gate closed |
| result_count | output | CW | Cycle count N of the last measurement |
| result_periods | output | MW | Period count M applied to the result |
| accum_sum | output | CW+2^KW−1 | Sum of the measurements since arm |
| accum_avg | output | CW | accum_sum shifted right by repeat_log2 |

## Verification
Intervals of 1, 5 and 37 cycles separate off-by-one counting errors from synchroniser latency that does not cancel. A spurious stop before the start, and a second start during counting, show whether each edge is qualified by the measurement phase. Gated runs with several M values, including zero, separate edge counting from cycle counting. A run of four unequal intervals exposes a wrong shift or a done pulse that comes early. An interval that never stops, and an arm sent while the block is busy, test saturation and the arm lockout.

// File: rtl/ivm_pkg.sv
package ivm_pkg;
  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'd0,
    MODE_FREQ     = 2'd1,
    MODE_REPEAT   = 2'd2,
    MODE_ALT      = 2'd3
  } meas_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_HOLD = 2'd3
  } meter_state_e;

  function automatic meas_mode_e norm_mode(input logic [1:0] m);
    return (m == MODE_ALT) ? MODE_INTERVAL : meas_mode_e'(m);
  endfunction
endpackage

// File: rtl/ivm_sync_edge.sv
module ivm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= async_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b0;
      else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;

  // an edge event can never last two cycles
  assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/ivm_counter.sv
module ivm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         at_max
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (v == TOP) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= {{(W-1){1'b0}}, 1'b1};
    else if (en)      cnt <= sat_inc(cnt);
  end

  assign at_max = (cnt == TOP);

  assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    at_max && en && !restart |=> at_max);
endmodule

// File: rtl/ivm_accum.sv
module ivm_accum #(
  parameter int IW = 16,
  parameter int AW = 23,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add,
  input  logic [IW-1:0] val,
  input  logic [SW-1:0] shift,
  output logic [AW-1:0] sum,
  output logic [IW-1:0] avg
);
  function automatic logic [IW-1:0] avg_of(input logic [AW-1:0] s,
                                           input logic [SW-1:0] sh);
    logic [AW-1:0] t;
    t = s >> sh;
    return t[IW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sum <= '0;
    else if (clr) sum <= '0;
    else if (add) sum <= sum + AW'(val);
  end

  assign avg = avg_of(sum, shift);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> sum == '0);
endmodule

// File: rtl/interval_freq_meter.sv
module interval_freq_meter
  import ivm_pkg::*;
#(
  parameter int CW = 16,
  parameter int MW = 8,
  parameter int KW = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arm,
  input  logic [1:0]             mode,
  input  logic [MW-1:0]          periods_m,
  input  logic [KW-1:0]          repeat_log2,
  input  logic                   start_in,
  input  logic                   stop_in,
  input  logic                   ack,
  output logic                   busy,
  output logic                   done,
  output logic                   overflow,
  output logic [CW-1:0]          result_count,
  output logic [MW-1:0]          result_periods,
  output logic [CW+(1<<KW)-2:0]  accum_sum,
  output logic [CW-1:0]          accum_avg
);
  localparam int REPW = (1 << KW) - 1;
  localparam int AW   = CW + REPW;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  function automatic logic [REPW-1:0] k_last(input logic [KW-1:0] sh);
    logic [REPW:0] t;
    t = ({{REPW{1'b0}}, 1'b1} << sh) - 1'b1;
    return t[REPW-1:0];
  endfunction

  function automatic logic [MW-1:0] eff_periods(input logic [1:0] m,
                                                input logic [MW-1:0] p);
    return (norm_mode(m) == MODE_FREQ && p != '0) ? p : MW'(1);
  endfunction

  meter_state_e    state_q;
  meas_mode_e      mode_q;
  logic [MW-1:0]   per_q, pc_q;
  logic [KW-1:0]   shl_q;
  logic [REPW-1:0] rep_q;
  logic [CW-1:0]   cnt;
  logic            cnt_at_max;
  logic            start_rise, stop_rise;

  // named internal events
  logic arm_accept, meas_begin, running, is_freq, is_rep;
  logic stop_hit, period_hit, gate_close, sat_stop, meas_end, rep_more, finish, take;

  ivm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_start (
    .clk(clk), .rst_n(rst_n), .async_in(start_in), .rise(start_rise));
  ivm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_stop (
    .clk(clk), .rst_n(rst_n), .async_in(stop_in), .rise(stop_rise));

  assign arm_accept = arm && (state_q == ST_IDLE);
  assign meas_begin = (state_q == ST_WAIT) && start_rise;
  assign running    = (state_q == ST_RUN);
  assign is_freq    = (mode_q == MODE_FREQ);
  assign is_rep     = (mode_q == MODE_REPEAT);
  assign stop_hit   = running && !is_freq && stop_rise;
  assign period_hit = running && is_freq && start_rise;
  assign gate_close = period_hit && (pc_q == per_q - 1'b1);
  assign sat_stop   = running && cnt_at_max && !stop_hit && !gate_close;
  assign meas_end   = stop_hit || gate_close || sat_stop;
  assign rep_more   = meas_end && is_rep && !sat_stop && (rep_q != k_last(shl_q));
  assign finish     = meas_end && !rep_more;
  assign take       = ack && (state_q == ST_HOLD);

  ivm_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(meas_begin), .en(running),
    .cnt(cnt), .at_max(cnt_at_max));

  ivm_accum #(.IW(CW), .AW(AW), .SW(KW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(arm_accept), .add(meas_end), .val(cnt),
    .shift(shl_q), .sum(accum_sum), .avg(accum_avg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (arm_accept) state_q <= ST_WAIT;
        ST_WAIT: if (meas_begin) state_q <= ST_RUN;
        ST_RUN: begin
          if (finish)        state_q <= ST_HOLD;
          else if (rep_more) state_q <= ST_WAIT;
        end
        ST_HOLD: if (take) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_INTERVAL;
      per_q  <= MW'(1);
      shl_q  <= '0;
    end else if (arm_accept) begin
      mode_q <= norm_mode(mode);
      per_q  <= eff_periods(mode, periods_m);
      shl_q  <= (norm_mode(mode) == MODE_REPEAT) ? repeat_log2 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc_q <= '0;
    else if (meas_begin) pc_q <= '0;
    else if (period_hit) pc_q <= pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rep_q <= '0;
    else if (arm_accept) rep_q <= '0;
    else if (rep_more)   rep_q <= rep_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done           <= 1'b0;
      overflow       <= 1'b0;
      result_count   <= '0;
      result_periods <= MW'(1);
    end else begin
      done <= finish;
      if (arm_accept) overflow <= 1'b0;
      if (finish) begin
        result_count   <= cnt;
        result_periods <= per_q;
        overflow       <= sat_stop;
      end
    end
  end

  assign busy = (state_q != ST_IDLE);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ack |=> busy);
  assert_arm_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && arm |=> $stable(mode_q) && $stable(per_q) && $stable(shl_q));
  assert_ovf_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> result_count == CMAX);
  assert_periods_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result_periods != '0);
endmodule

// File: tb/tb_interval_freq_meter.sv
module tb_interval_freq_meter;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int MW = 6;
  localparam int KW = 3;
  localparam int SW = CW + (1 << KW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 1'b0, start_in = 1'b0, stop_in = 1'b0, ack = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [MW-1:0] periods_m = '0;
  logic [KW-1:0] repeat_log2 = '0;
  logic busy, done, overflow;
  logic [CW-1:0] result_count, accum_avg;
  logic [MW-1:0] result_periods;
  logic [SW-1:0] accum_sum;

  int n_chk = 0, n_bad = 0, done_seen = 0;
  bit finished = 1'b0;

  interval_freq_meter #(.CW(CW), .MW(MW), .KW(KW)) dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .periods_m(periods_m),
    .repeat_log2(repeat_log2), .start_in(start_in), .stop_in(stop_in), .ack(ack),
    .busy(busy), .done(done), .overflow(overflow), .result_count(result_count),
    .result_periods(result_periods), .accum_sum(accum_sum), .accum_avg(accum_avg));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (rst_n && done) done_seen++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic arm_it(input logic [1:0] md, input int m, input int k);
    @(negedge clk);
    arm = 1'b1; mode = md; periods_m = MW'(m); repeat_log2 = KW'(k);
    @(negedge clk);
    arm = 1'b0; mode = 2'd1; periods_m = MW'(9); repeat_log2 = KW'(5);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_done(input int limit);
    int base = done_seen;
    int i = 0;
    while (done_seen == base && i < limit) begin
      @(posedge clk); i++;
    end
    @(negedge clk);
  endtask

  task automatic release_result(input string req);
    chk({req, " busy held"}, busy, 1);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk({req, " busy drop"}, busy, 0);
  endtask

  // start edge, optional extra start at 'extra', stop D cycles later
  task automatic interval(input int d, input int extra);
    start_in = 1'b1;
    for (int i = 1; i <= d; i++) begin
      @(negedge clk);
      if (i == 2) start_in = 1'b0;
      if (extra > 0 && i == extra) start_in = 1'b1;
      if (extra > 0 && i == extra + 2) start_in = 1'b0;
    end
    stop_in = 1'b1; start_in = 1'b0;
    repeat (2) @(negedge clk);
    stop_in = 1'b0;
  endtask

  task automatic t_interval(input int d);
    int base;
    arm_it(2'd0, 0, 0);
    base = done_seen;
    interval(d, 0);
    wait_done(20);
    @(negedge clk);
    chk("R2 interval count", result_count, d);
    chk("R9 periods in interval", result_periods, 1);
    chk("R7 one done pulse", done_seen - base, 1);
    chk("R2 no overflow", overflow, 0);
    release_result("R7");
  endtask

  task automatic t_spurious();
    arm_it(2'd0, 0, 0);
    stop_in = 1'b1; repeat (3) @(negedge clk); stop_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 stop before start ignored", done_seen == 0 ? 0 : int'(done), 0);
    interval(12, 5);
    wait_done(20);
    chk("R3 count ignores stray edges", result_count, 12);
    release_result("R3");
  endtask

  task automatic t_freq(input int m, input int p, input int exp_m);
    int base;
    arm_it(2'd1, m, 0);
    base = done_seen;
    for (int e = 0; e < exp_m + 2; e++) begin
      start_in = 1'b1; repeat (p/2) @(negedge clk);
      start_in = 1'b0; repeat (p - p/2) @(negedge clk);
    end
    wait_done(20);
    chk("R4 gated count", result_count, exp_m * p);
    chk("R4 period count", result_periods, exp_m);
    chk("R4 one done pulse", done_seen - base, 1);
    release_result("R4");
  endtask

  task automatic t_repeat();
    int base;
    int d[4] = '{5, 7, 9, 11};
    arm_it(2'd2, 0, 2);
    base = done_seen;
    for (int r = 0; r < 4; r++) begin
      interval(d[r], 0);
      repeat (4) @(negedge clk);
      if (r < 3) chk("R5 no early done", done_seen - base, 0);
    end
    wait_done(20);
    chk("R5 sum", int'(accum_sum), 32);
    chk("R5 average", accum_avg, 8);
    chk("R5 single done", done_seen - base, 1);
    chk("R9 periods in repeat", result_periods, 1);
    release_result("R5");
  endtask

  task automatic t_overflow();
    arm_it(2'd0, 0, 0);
    start_in = 1'b1; repeat (2) @(negedge clk); start_in = 1'b0;
    wait_done(1200);
    chk("R6 saturated count", result_count, (1 << CW) - 1);
    chk("R6 overflow flag", overflow, 1);
    release_result("R6");
  endtask

  task automatic t_arm_busy();
    int base;
    arm_it(2'd0, 0, 0);
    interval(4, 0);
    wait_done(20);
    base = done_seen;
    @(negedge clk); arm = 1'b1; mode = 2'd1; periods_m = MW'(2);
    @(negedge clk); arm = 1'b0;
    interval(7, 0);
    repeat (4) @(negedge clk);
    chk("R8 arm while busy ignored", done_seen - base, 0);
    chk("R8 result unchanged", result_count, 4);
    release_result("R8");
  endtask

  task automatic t_mode3();
    arm_it(2'd3, 5, 0);
    interval(6, 0);
    wait_done(20);
    chk("R9 mode 3 as interval", result_count, 6);
    chk("R9 mode 3 periods", result_periods, 1);
    release_result("R9");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 count", result_count, 0);
    chk("R1 periods", result_periods, 1);
    chk("R1 sum", int'(accum_sum), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", busy, 0);
    t_interval(1);
    t_interval(5);
    t_interval(37);
    t_spurious();
    t_freq(4, 6, 4);
    t_freq(0, 8, 1);
    t_freq(3, 5, 3);
    t_repeat();
    t_overflow();
    t_arm_busy();
    t_mode3();
    finish_run();
  end
endmodule